// File: doc/BRIEF.md
# Multi-channel PWM grayscale timing controller

This block turns one wide configuration word into twelve pulse-width modulated on/off enables. Each channel carries a 16-bit grayscale level. A channel stays on at the start of every counting period until a shared grayscale counter reaches that level. The same word carries three 7-bit group brightness levels, which are passed straight through to an external current stage. It also carries five function bits that control the timing: forced blanking, one-shot or repeating periods, counter restart on every capture, the reference clock source, and the active edge of that clock.

Everything runs on one fast system clock. The reference clock is either an internal oscillator tick or a serial clock line. It is treated as data: it passes through a two-flop synchronizer, and each selected edge moves the counter on by one count. A capture strobe copies the word into an internal register, and from then on only that copy drives the outputs.

Top module: `pwm_gs_ctrl`

## Requirements
- R1: Channel index c = 3*group + colour (colour order red, green, blue; groups 0..3) takes its grayscale level from word bits 16c+15..16c. The red, green and blue brightness levels sit in bits 198..192, 205..199 and 212..206, and appear on `bright_r`, `bright_g` and `bright_b` from the cycle after a capture.
- R2: The word is copied only on a system clock edge where `latch_stb` is 1. Changes to `cfg_word` without a strobe have no effect on any output.
- R3: While the captured bit 213 (blank) is 1, all twelve enables are 0, and the counter is held at 0 with the captured levels loaded. Once blank returns to 0, a new period starts from count 0.
- R4: After reset, the captured word reads as blank = 1 with every other bit 0. All enables and brightness outputs are therefore 0.
- R5: With captured bit 214 (repeat) at 0, the counter stops after one full period. The enables then stay 0 until blank is set or a restart capture occurs.
- R6: With bit 214 at 1, the counter wraps from its maximum value to 0 and the on/off pattern repeats every 2^16 reference edges.
- R7: A strobe whose incoming word has bit 215 (restart) at 1 clears the counter, cancels a stopped one-shot and applies the new levels in the same edge. With bit 215 at 0, a strobe leaves the counter untouched, and new levels take effect only when the counter next wraps.
- R8: Captured bit 216 selects the reference clock: 0 selects `osc_tick` and 1 selects `sclk_in`. Activity on the other input does not move the counter.
- R9: Captured bit 217 selects the counting edge: 1 counts rising edges and 0 counts falling edges. The input is sampled by two flops, and the counter advances once, on the system clock edge after the second flop shows the transition.
- R10: A channel is on while the counter is below its level. A level of 0 never turns it on, and the maximum level keeps it on for all but one count of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_word | input | 218 | Grayscale, brightness and function word to capture |
| latch_stb | input | 1 | Capture strobe, one system clock wide |
| osc_tick | input | 1 | Internal oscillator reference clock |
| sclk_in | input | 1 | Serial clock line used as an alternative reference |
| chan_on | output | 12 | Per-channel output enables, index 3*group + colour |
| bright_r | output | 7 | Captured red brightness level |
| bright_g | output | 7 | Captured green brightness level |
| bright_b | output | 7 | Captured blue brightness level |

## Verification
The hardest states to reach from the ports are the end of a full period: the wrap that applies deferred levels, and the permanent stop in one-shot mode. Both sit 2^16 reference edges away at the default width. The bench therefore builds the block with 6-bit levels, so a period is 64 edges. It toggles the reference inputs every cycle or every third cycle, crossing several wraps and one-shot stops. Between wraps it captures new words with and without the restart bit, switches the clock source and edge, and writes the word without a strobe.

// File: rtl/pwm_gs_pkg.sv
package pwm_gs_pkg;
  // Function field, packed so that bit 0 is the lowest function bit of the word.
  typedef struct packed {
    logic rise;     // 1: count rising edges
    logic extsrc;   // 1: serial clock line is the reference
    logic restart;  // 1: capture restarts the period
    logic rpt;      // 1: periods repeat
    logic blank;    // 1: outputs forced off
  } fc_t;

  localparam int FC_W = $bits(fc_t);
  localparam int N_COLOUR = 3;
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg #(
  parameter int W     = 218,
  parameter int BLANK = 213
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = {{(W-1){1'b0}}, 1'b1} << BLANK;

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (stb) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (stb) q <= q_nxt;
  end
endmodule

// File: rtl/pwm_ref_edge.sv
module pwm_ref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic osc,
  input  logic sclk,
  input  logic sel_ext,
  input  logic sel_rise,
  output logic edge_o
);
  logic src, sync1, sync2, prev;
  logic rise_det, fall_det;

  always_comb begin
    src      = sel_ext ? sclk : osc;
    rise_det = sync2 & ~prev;
    fall_det = ~sync2 & prev;
    edge_o   = sel_rise ? rise_det : fall_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= src;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  // R9: two rising detections can never be back to back
  p_edge_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && sel_rise) |=> !(edge_o && sel_rise));
endmodule

// File: rtl/pwm_gs_timer.sv
module pwm_gs_timer #(
  parameter int GS_W = 16,
  parameter int NCH  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 blank,
  input  logic                 rpt,
  input  logic                 restart,
  input  logic                 step,
  input  logic [NCH*GS_W-1:0]  gs_pend,
  input  logic [NCH*GS_W-1:0]  gs_new,
  output logic [GS_W-1:0]      cnt,
  output logic                 done,
  output logic [NCH*GS_W-1:0]  gs_act
);
  localparam logic [GS_W-1:0] CNT_MAX = '1;

  logic [GS_W-1:0]     cnt_nxt;
  logic                done_nxt;
  logic [NCH*GS_W-1:0] act_nxt;
  logic                upd_en;

  always_comb begin
    cnt_nxt  = cnt;
    done_nxt = done;
    act_nxt  = gs_act;
    upd_en   = 1'b0;
    if (restart) begin
      cnt_nxt  = '0;
      done_nxt = 1'b0;
      act_nxt  = gs_new;
      upd_en   = 1'b1;
    end else if (blank) begin
      cnt_nxt  = '0;
      done_nxt = 1'b0;
      act_nxt  = gs_pend;
      upd_en   = 1'b1;
    end else if (step && !done) begin
      upd_en = 1'b1;
      if (cnt == CNT_MAX) begin
        cnt_nxt = '0;
        act_nxt = gs_pend;
        if (!rpt) done_nxt = 1'b1;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done   <= 1'b0;
      gs_act <= '0;
    end else if (upd_en) begin
      cnt    <= cnt_nxt;
      done   <= done_nxt;
      gs_act <= act_nxt;
    end
  end

  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && !done);
  p_blank_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (cnt == '0) && !done);
  p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !blank && !restart) |=> done && (cnt == '0));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !blank && !restart) |=> $stable(cnt));
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
  parameter int GS_W = 16,
  parameter int NCH  = 12
) (
  input  logic [GS_W-1:0]     cnt,
  input  logic [NCH*GS_W-1:0] gs_act,
  input  logic                en,
  output logic [NCH-1:0]      on
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb on[c] = en && (cnt < gs_act[c*GS_W +: GS_W]);
  end
endmodule

// File: rtl/pwm_gs_ctrl.sv
module pwm_gs_ctrl #(
  parameter int GS_W   = 16,
  parameter int BR_W   = 7,
  parameter int N_GRP  = 4,
  localparam int NCH   = N_GRP * pwm_gs_pkg::N_COLOUR,
  localparam int GS_TOT = NCH * GS_W,
  localparam int BR_LO = GS_TOT,
  localparam int FC_LO = BR_LO + pwm_gs_pkg::N_COLOUR * BR_W,
  localparam int W     = FC_LO + pwm_gs_pkg::FC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    cfg_word,
  input  logic            latch_stb,
  input  logic            osc_tick,
  input  logic            sclk_in,
  output logic [NCH-1:0]  chan_on,
  output logic [BR_W-1:0] bright_r,
  output logic [BR_W-1:0] bright_g,
  output logic [BR_W-1:0] bright_b
);
  import pwm_gs_pkg::*;

  logic        rs_meta, srst_n;
  logic [W-1:0] cfg_q;
  fc_t         fc_q, fc_in;
  logic        ref_edge, restart;
  logic [GS_W-1:0]   cnt;
  logic              done;
  logic [GS_TOT-1:0] gs_act;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      srst_n  <= rs_meta;
    end
  end

  pwm_cfg_reg #(.W(W), .BLANK(FC_LO)) u_cfg (
    .clk(clk), .rst_n(srst_n), .stb(latch_stb), .d(cfg_word), .q(cfg_q)
  );

  always_comb begin
    fc_q     = fc_t'(cfg_q[FC_LO +: FC_W]);
    fc_in    = fc_t'(cfg_word[FC_LO +: FC_W]);
    restart  = latch_stb && fc_in.restart;
    bright_r = cfg_q[BR_LO +: BR_W];
    bright_g = cfg_q[BR_LO + BR_W +: BR_W];
    bright_b = cfg_q[BR_LO + 2*BR_W +: BR_W];
  end

  pwm_ref_edge u_edge (
    .clk(clk), .rst_n(srst_n), .osc(osc_tick), .sclk(sclk_in),
    .sel_ext(fc_q.extsrc), .sel_rise(fc_q.rise), .edge_o(ref_edge)
  );

  pwm_gs_timer #(.GS_W(GS_W), .NCH(NCH)) u_timer (
    .clk(clk), .rst_n(srst_n), .blank(fc_q.blank), .rpt(fc_q.rpt),
    .restart(restart), .step(ref_edge),
    .gs_pend(cfg_q[GS_TOT-1:0]), .gs_new(cfg_word[GS_TOT-1:0]),
    .cnt(cnt), .done(done), .gs_act(gs_act)
  );

  pwm_chan_cmp #(.GS_W(GS_W), .NCH(NCH)) u_cmp (
    .cnt(cnt), .gs_act(gs_act), .en(!fc_q.blank && !done), .on(chan_on)
  );

  p_blank_off_r3: assert property (@(posedge clk) disable iff (!srst_n)
    fc_q.blank |-> (chan_on == '0));
  p_oneshot_off_r5: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (chan_on == '0));
  p_bright_cap_r1: assert property (@(posedge clk) disable iff (!srst_n)
    latch_stb |=> (bright_g == $past(cfg_word[BR_LO + BR_W +: BR_W])));
  p_hold_word_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !latch_stb |=> $stable(cfg_q));
endmodule

// File: tb/pwm_gs_ctrl_test.sv
module pwm_gs_ctrl_test;
  localparam int GS_W = 6;
  localparam int BR_W = 7;
  localparam int NCH  = 12;
  localparam int BR0  = NCH * GS_W;
  localparam int F0   = BR0 + 3 * BR_W;
  localparam int W    = F0 + 5;
  localparam int PER  = 1 << GS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [W-1:0] cfg_word = '0;
  logic latch_stb = 1'b0, osc_tick = 1'b0, sclk_in = 1'b0;
  logic [NCH-1:0] chan_on;
  logic [BR_W-1:0] bright_r, bright_g, bright_b;

  int vectors = 0, errors = 0;
  string cur_req = "R4";
  bit chk_en = 1'b0;
  int gs_set[NCH];

  always #5 clk = ~clk;

  pwm_gs_ctrl #(.GS_W(GS_W), .BR_W(BR_W), .N_GRP(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .latch_stb(latch_stb),
    .osc_tick(osc_tick), .sclk_in(sclk_in), .chan_on(chan_on),
    .bright_r(bright_r), .bright_g(bright_g), .bright_b(bright_b)
  );

  // ---------------- behavioural reference ----------------
  logic [W-1:0] m_cfg;
  int  m_cnt, rel;
  bit  m_done;
  int  m_act[NCH];
  bit  hist[$];
  bit  b_blank, b_rpt, b_ext, b_rise, ev, smp, old2, old3;

  task automatic m_reset();
    m_cfg = '0; m_cfg[F0] = 1'b1;
    m_cnt = 0; m_done = 0;
    foreach (m_act[i]) m_act[i] = 0;
    hist = '{0, 0, 0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset(); rel = 0;
    end else if (rel < 2) begin
      m_reset(); rel++;
    end else begin
      b_blank = m_cfg[F0];   b_rpt  = m_cfg[F0+1];
      b_ext   = m_cfg[F0+3]; b_rise = m_cfg[F0+4];
      smp  = b_ext ? sclk_in : osc_tick;
      old2 = hist[1]; old3 = hist[2];
      ev = b_rise ? (old2 && !old3) : (!old2 && old3);
      if (latch_stb && cfg_word[F0+2]) begin
        m_cnt = 0; m_done = 0;
        for (int i = 0; i < NCH; i++) m_act[i] = int'(cfg_word[i*GS_W +: GS_W]);
      end else if (b_blank) begin
        m_cnt = 0; m_done = 0;
        for (int i = 0; i < NCH; i++) m_act[i] = int'(m_cfg[i*GS_W +: GS_W]);
      end else if (ev && !m_done) begin
        if (m_cnt == PER - 1) begin
          m_cnt = 0;
          for (int i = 0; i < NCH; i++) m_act[i] = int'(m_cfg[i*GS_W +: GS_W]);
          if (!b_rpt) m_done = 1;
        end else m_cnt++;
      end
      if (latch_stb) m_cfg = cfg_word;
      hist.push_front(smp);
      void'(hist.pop_back());
    end
  end

  function automatic logic [NCH-1:0] exp_on();
    logic [NCH-1:0] r = '0;
    for (int i = 0; i < NCH; i++)
      r[i] = !m_cfg[F0] && !m_done && (m_cnt < m_act[i]);
    return r;
  endfunction

  always @(negedge clk) begin
    if (chk_en) begin
      vectors++;
      if (chan_on !== exp_on()) begin
        errors++;
        $display("FAIL %s chan_on got %h expected %h", cur_req, chan_on, exp_on());
      end
      if (bright_r !== m_cfg[BR0 +: BR_W] || bright_g !== m_cfg[BR0+BR_W +: BR_W] ||
          bright_b !== m_cfg[BR0+2*BR_W +: BR_W]) begin
        errors++;
        $display("FAIL %s bright got %h/%h/%h expected %h/%h/%h", cur_req,
                 bright_r, bright_g, bright_b, m_cfg[BR0 +: BR_W],
                 m_cfg[BR0+BR_W +: BR_W], m_cfg[BR0+2*BR_W +: BR_W]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [W-1:0] mk(int br, int bg, int bb, bit blank, bit rpt,
                                      bit rst, bit ext, bit rise);
    logic [W-1:0] w = '0;
    for (int i = 0; i < NCH; i++) w[i*GS_W +: GS_W] = GS_W'(gs_set[i]);
    w[BR0 +: BR_W] = BR_W'(br);
    w[BR0+BR_W +: BR_W] = BR_W'(bg);
    w[BR0+2*BR_W +: BR_W] = BR_W'(bb);
    w[F0] = blank; w[F0+1] = rpt; w[F0+2] = rst; w[F0+3] = ext; w[F0+4] = rise;
    return w;
  endfunction

  task automatic capture(logic [W-1:0] w);
    @(negedge clk); cfg_word = w; latch_stb = 1'b1;
    @(negedge clk); latch_stb = 1'b0;
  endtask

  // src: 0 osc, 1 sclk; div: toggle period in cycles, 0 = idle
  task automatic run(int n, bit src, int div);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (div != 0 && (k % div) == 0) begin
        if (src) sclk_in = ~sclk_in; else osc_tick = ~osc_tick;
      end
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #30 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4: reset state
    cur_req = "R4"; chk_en = 1'b1;
    run(5, 0, 1);

    // R1 R6 R10: repeating, rising osc edges, varied levels incl. 0 and max
    cur_req = "R10";
    foreach (gs_set[i]) gs_set[i] = (i * 7 + 3) % PER;
    gs_set[0] = 0; gs_set[5] = PER - 1; gs_set[11] = 1;
    capture(mk(17, 85, 126, 0, 1, 0, 0, 1));
    cur_req = "R6";
    run(300, 0, 1);

    // R7: capture without restart, levels wait for wrap
    cur_req = "R7";
    foreach (gs_set[i]) gs_set[i] = PER - 1 - (i * 5) % PER;
    capture(mk(3, 4, 5, 0, 1, 0, 0, 1));
    run(200, 0, 1);

    // R2: word changes without a strobe
    cur_req = "R2";
    cfg_word = mk(99, 98, 97, 1, 0, 1, 1, 0);
    run(60, 0, 1);

    // R7: restart capture applies levels at once
    cur_req = "R7";
    foreach (gs_set[i]) gs_set[i] = (i * 11 + 9) % PER;
    capture(mk(1, 2, 3, 0, 1, 1, 0, 1));
    run(90, 0, 1);

    // R5: one-shot then permanent off, then restart capture revives
    cur_req = "R5";
    capture(mk(1, 2, 3, 0, 0, 1, 0, 1));
    run(260, 0, 1);
    capture(mk(6, 7, 8, 0, 0, 1, 0, 1));
    run(60, 0, 1);

    // R3: blank holds off, release restarts
    cur_req = "R3";
    capture(mk(6, 7, 8, 1, 1, 0, 0, 1));
    run(40, 0, 1);
    capture(mk(6, 7, 8, 0, 1, 0, 0, 1));
    run(80, 0, 1);

    // R8: serial clock as reference; osc activity ignored
    cur_req = "R8";
    capture(mk(9, 10, 11, 0, 1, 1, 1, 1));
    run(150, 1, 3);
    run(60, 0, 1);
    run(60, 1, 1);

    // R9: falling edges, slower irregular pace
    cur_req = "R9";
    capture(mk(12, 13, 14, 0, 1, 1, 0, 0));
    run(200, 0, 3);
    run(100, 0, 2);
    capture(mk(12, 13, 14, 0, 0, 0, 0, 1));
    run(400, 0, 1);

    chk_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule